// File: doc/BRIEF.md
# Asynchronous Serial Port with Address-Flag Framing

This block is a full-duplex asynchronous serial transmitter and receiver reached through a four-register interface. A divisor input sets the rate of a 16x tick, so one bit lasts sixteen ticks. The transmitter sends bytes least significant bit first, with a low start bit, eight data bits, an optional ninth bit and a high stop bit. It has its own enable and an optional clear-to-send gate. The receiver oversamples the line, confirms each start bit half a bit after its falling edge and reports data, error and framing status.

The ninth bit is either a parity bit (even or odd) or, in multiprocessor mode, an address/data flag that takes the place of parity. A byte received with the flag set is an address byte. The next data byte after it is marked as the first data byte of a new frame. The flag value of the most recent byte is also reported. All receive status clears when the receive data register is read.

Register map, selected by `reg_addr`. Address 0 is data: a write queues a transmit byte, a read returns the received byte and clears the receive flags. Address 1 is status and is read-only: bit 0 byte ready, bit 1 new frame, bit 2 last flag bit, bit 3 parity error, bit 4 framing error, bit 5 overrun, bit 6 transmitter busy. Address 2 is control: bit 0 transmit enable, bit 1 receive enable, bit 2 clear-to-send gating, bit 3 flag bit to send. Address 3 is configuration: bit 0 parity on, bit 1 odd parity, bit 2 multiprocessor mode.

Top module: `uart_mpx`

## Requirements
- R1: After reset, `tx_out` is 1, the status register reads 0x00 and the configuration register reads 0x00.
- R2: A transmitted frame is a 0 start bit, then data bits 0 to 7, then the ninth bit when enabled, then a 1 stop bit. Each bit lasts 16 ticks, and one tick occurs every `baud_div` clocks.
- R3: A queued byte starts only when control bit 0 is 1. If control bit 2 is 1, `cts_n` must also be 0 for it to start. If control bit 2 is 0, `cts_n` has no effect.
- R4: With configuration bit 0 set and bit 2 clear, the ninth bit equals the XOR of the data bits XOR configuration bit 1. The receiver sets status bit 3 when the received ninth bit differs from this value.
- R5: With configuration bit 2 set, the ninth bit carries control bit 3 whatever configuration bit 0 holds, and no parity error is ever flagged. Status bit 2 holds the ninth bit of the last received byte.
- R6: In multiprocessor mode, status bit 1 is 1 only for the first byte with flag 0 that follows a byte with flag 1. Address bytes and later data bytes leave it 0.
- R7: Reading address 0 clears status bits 0 to 5, unless a new byte completes in the same cycle.
- R8: Status bit 4 is set when the stop bit is sampled low. The data byte is still delivered.
- R9: Status bit 5 is set when a byte completes while status bit 0 is still set. The newer byte replaces the older one.
- R10: While control bit 1 is 0, the receiver ignores `rx_in` and no byte completes.
- R11: Writes to address 3 are ignored while control bit 0 or bit 1 is set.
- R12: A low pulse on `rx_in` that is gone before the middle of the start bit is rejected, and no byte is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Clocks per 16x tick (0 treated as 1) |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| rx_in | input | 1 | Serial receive line, idle high |
| cts_n | input | 1 | Clear-to-send, active low |
| tx_out | output | 1 | Serial transmit line, idle high |

## Verification
The bench sends address and data bytes so that the new-frame flag is tested on the byte after an address, and not on later bytes. A design that set it on every data byte, or kept it after a read, would show the wrong value. Parity is tested with data whose even parity differs from the flag bit being sent. A design that let parity win over multiprocessor mode would therefore send the wrong ninth bit. The clear-to-send gate is held off for many bit times to show that a byte stays queued and is not lost. A glitch on the receive line that is shorter than half a bit must not produce a byte. A bad stop bit must be flagged without producing a byte from the low tail of that stop bit. A locked configuration write is read back after the port is disabled, to show that it never landed.

// File: rtl/uart_mpx.sv
module uart_mpx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             rx_in,
  input  logic             cts_n,
  output logic             tx_out
);

  logic [DIV_W-1:0] div_cnt;
  logic tick;
  assign tick = (div_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= (baud_div == '0) ? '0 : baud_div - 1'b1;
    else           div_cnt <= div_cnt - 1'b1;
  end

  logic [3:0] ctrl_q;
  logic [2:0] cfg_q;
  logic en_any, extra, mp_mode;
  assign en_any  = ctrl_q[0] | ctrl_q[1];
  assign mp_mode = cfg_q[2];
  assign extra   = cfg_q[2] | cfg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd2) ctrl_q <= reg_wdata[3:0];
      if (reg_addr == 2'd3 && !en_any) cfg_q <= reg_wdata[2:0];
    end
  end

  // transmitter
  logic        tx_pend, tx_act, tx_go, tx_load, tx_xbit;
  logic [7:0]  tx_hold;
  logic [10:0] tx_sh;
  logic [3:0]  tx_sub, tx_idx, tx_last;

  assign tx_go   = ctrl_q[0] && (!ctrl_q[2] || !cts_n);
  assign tx_load = tx_pend && !tx_act && tx_go;
  assign tx_xbit = mp_mode ? ctrl_q[3] : (^tx_hold ^ cfg_q[1]);
  assign tx_last = extra ? 4'd10 : 4'd9;
  assign tx_out  = tx_act ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_pend <= 1'b0;
      tx_hold <= '0;
      tx_act  <= 1'b0;
      tx_sh   <= '1;
      tx_sub  <= '0;
      tx_idx  <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0 && !tx_pend) begin
        tx_pend <= 1'b1;
        tx_hold <= reg_wdata;
      end
      if (tx_load) begin
        tx_pend <= 1'b0;
        tx_act  <= 1'b1;
        tx_sh   <= extra ? {1'b1, tx_xbit, tx_hold, 1'b0} : {2'b11, tx_hold, 1'b0};
        tx_sub  <= '0;
        tx_idx  <= '0;
      end else if (tx_act && tick) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == 4'd15) begin
          tx_sh  <= {1'b1, tx_sh[10:1]};
          tx_idx <= tx_idx + 1'b1;
          if (tx_idx == tx_last) tx_act <= 1'b0;
        end
      end
    end
  end

  // receiver
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_state_t;
  rx_state_t  rx_st;
  logic [1:0] rx_sync;
  logic       rxs, rx_x, rx_done, rd_data, par_bad;
  logic [3:0] rx_sub, rx_idx, rx_last;
  logic [7:0] rx_sh, rx_data;
  logic       rx_ready, newfrm, mpbit, perr, ferr, ovr, addr_seen;

  assign rxs     = rx_sync[1];
  assign rx_last = extra ? 4'd9 : 4'd8;
  assign rx_done = (rx_st == R_BITS) && tick && (rx_sub == 4'd15) && (rx_idx == rx_last);
  assign rd_data = reg_rd && (reg_addr == 2'd0);
  assign par_bad = cfg_q[0] && !mp_mode && (rx_x != (^rx_sh ^ cfg_q[1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      rx_st   <= R_IDLE;
      rx_sub  <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      rx_x    <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rx_in};
      if (!ctrl_q[1]) rx_st <= R_IDLE;
      else if (tick) begin
        case (rx_st)
          R_IDLE: if (!rxs) begin
            rx_st  <= R_START;
            rx_sub <= '0;
          end
          R_START: begin
            rx_sub <= rx_sub + 1'b1;
            if (rx_sub == 4'd7) begin
              rx_sub <= '0;
              rx_idx <= '0;
              rx_st  <= rxs ? R_IDLE : R_BITS;
            end
          end
          R_BITS: begin
            rx_sub <= rx_sub + 1'b1;
            if (rx_sub == 4'd15) begin
              if (rx_idx < 4'd8)   rx_sh <= {rxs, rx_sh[7:1]};
              else if (extra && rx_idx == 4'd8) rx_x <= rxs;
              rx_idx <= rx_idx + 1'b1;
              if (rx_idx == rx_last) rx_st <= R_IDLE;
            end
          end
          default: rx_st <= R_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      {rx_ready, newfrm, mpbit, perr, ferr, ovr, addr_seen} <= '0;
    end else begin
      if (rd_data) {rx_ready, newfrm, mpbit, perr, ferr, ovr} <= '0;
      if (rx_done) begin
        rx_data  <= rx_sh;
        rx_ready <= 1'b1;
        ovr      <= (ovr || rx_ready) && !rd_data;
        ferr     <= !rxs;
        perr     <= par_bad;
        mpbit    <= mp_mode && rx_x;
        if (mp_mode && rx_x) begin
          addr_seen <= 1'b1;
          newfrm    <= 1'b0;
        end else if (mp_mode) begin
          newfrm    <= addr_seen;
          addr_seen <= 1'b0;
        end else begin
          newfrm    <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = rx_data;
      2'd1:    reg_rdata = {1'b0, tx_pend | tx_act, ovr, ferr, perr, mpbit, newfrm, rx_ready};
      2'd2:    reg_rdata = {4'b0, ctrl_q};
      default: reg_rdata = {5'b0, cfg_q};
    endcase
  end

endmodule

// File: rtl/uart_mpx_chk.sv
module uart_mpx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_out,
  input logic       tx_act,
  input logic       cts_n,
  input logic [3:0] ctrl_q,
  input logic [2:0] cfg_q,
  input logic       en_any,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       rx_done,
  input logic       rx_ready,
  input logic       newfrm,
  input logic       mpbit,
  input logic       ovr
);

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_act) |-> !tx_out); // R2

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_act) |-> $past(ctrl_q[0] && (!ctrl_q[2] || !cts_n))); // R3

  AST_NEWFRM_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    newfrm |-> rx_ready); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && !rx_done) |=> (!rx_ready && !newfrm && !mpbit)); // R7

  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_ready && !(reg_rd && reg_addr == 2'd0)) |=> ovr); // R9

  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |=> !rx_done); // R10

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    en_any |=> $stable(cfg_q)); // R11

endmodule

bind uart_mpx uart_mpx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .tx_act(tx_act), .cts_n(cts_n),
  .ctrl_q(ctrl_q), .cfg_q(cfg_q), .en_any(en_any), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .rx_done(rx_done), .rx_ready(rx_ready),
  .newfrm(newfrm), .mpbit(mpbit), .ovr(ovr)
);

// File: tb/sim_uart_mpx.sv
`timescale 1ns/1ps
module sim_uart_mpx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        rx_in = 1'b1, cts_n = 1'b0;
  logic        tx_out;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_mpx #(.DIV_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_in(rx_in), .cts_n(cts_n), .tx_out(tx_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk); reg_addr = 2'd0; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit has_x, input bit x, input bit stop);
    logic [10:0] f;
    int nb;
    f  = has_x ? {1'b1, x, d, 1'b0} : {2'b11, d, 1'b0};
    nb = has_x ? 11 : 10;
    if (!stop) f[nb-1] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rx_in = f[i];
      if (i == nb - 1 && !stop) begin
        idle(11); rx_in = 1'b1; idle(4);
      end else idle(15);
    end
    @(negedge clk); rx_in = 1'b1;
    idle(4);
  endtask

  task automatic grab_tx(input int nb, input int bcyc, output logic [10:0] bits, output bit seen);
    seen = 0; bits = '1;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (!tx_out) seen = 1;
    end
    if (seen) begin
      idle(bcyc / 2 - 1);
      bits[0] = tx_out;
      for (int i = 1; i < nb; i++) begin
        idle(bcyc);
        bits[i] = tx_out;
      end
      idle(bcyc);
    end
  endtask

  task automatic quiet_tx(input int n, output bit stayed);
    stayed = 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!tx_out) stayed = 0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check(tx_out === 1'b1, "R1 tx idle", tx_out, 1);
    rd_reg(2'd1, v); check(v === 8'h00, "R1 status", v, 8'h00);
    rd_reg(2'd3, v); check(v === 8'h00, "R1 config", v, 8'h00);
  endtask

  task automatic t_tx_frame;
    logic [10:0] b; bit s;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hA5);
    grab_tx(10, 16, b, s);
    check(s && b[9:0] === {1'b1, 8'hA5, 1'b0}, "R2 frame div1", b[9:0], {1'b1, 8'hA5, 1'b0});
    baud_div = 16'd3;
    wr(2'd0, 8'h3C);
    grab_tx(10, 48, b, s);
    check(s && b[9:0] === {1'b1, 8'h3C, 1'b0}, "R2 frame div3", b[9:0], {1'b1, 8'h3C, 1'b0});
    baud_div = 16'd1;
    idle(20);
  endtask

  task automatic t_cts;
    logic [10:0] b; bit s, q; logic [7:0] v;
    wr(2'd2, 8'h05); cts_n = 1'b1;
    wr(2'd0, 8'h55);
    quiet_tx(80, q); check(q, "R3 cts blocks", q, 1);
    rd_reg(2'd1, v); check(v[6] === 1'b1, "R3 byte held", v[6], 1);
    cts_n = 1'b0;
    grab_tx(10, 16, b, s);
    check(s && b[9:0] === {1'b1, 8'h55, 1'b0}, "R3 after cts", b[9:0], {1'b1, 8'h55, 1'b0});
    wr(2'd2, 8'h01); cts_n = 1'b1;
    wr(2'd0, 8'h0F);
    grab_tx(10, 16, b, s);
    check(s && b[9:0] === {1'b1, 8'h0F, 1'b0}, "R3 cts ignored", b[9:0], {1'b1, 8'h0F, 1'b0});
    cts_n = 1'b0;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h11);
    quiet_tx(80, q); check(q, "R3 tx disabled", q, 1);
    wr(2'd2, 8'h01);
    grab_tx(10, 16, b, s);
    check(s && b[9:0] === {1'b1, 8'h11, 1'b0}, "R3 on enable", b[9:0], {1'b1, 8'h11, 1'b0});
    wr(2'd2, 8'h00);
  endtask

  task automatic t_cfg_lock;
    logic [7:0] v;
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h03);
    wr(2'd2, 8'h00);
    rd_reg(2'd3, v); check(v === 8'h00, "R11 locked rx", v, 8'h00);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h05);
    wr(2'd2, 8'h00);
    rd_reg(2'd3, v); check(v === 8'h00, "R11 locked tx", v, 8'h00);
    wr(2'd3, 8'h03);
    rd_reg(2'd3, v); check(v === 8'h03, "R11 unlocked", v, 8'h03);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_parity;
    logic [10:0] b; bit s; logic [7:0] v;
    wr(2'd3, 8'h01); wr(2'd2, 8'h03);
    wr(2'd0, 8'h07);
    grab_tx(11, 16, b, s);
    check(s && b === {2'b11, 8'h07, 1'b0}, "R4 even tx", b, {2'b11, 8'h07, 1'b0});
    send_rx(8'h07, 1, 1, 1);
    rd_reg(2'd1, v); check(v[3] === 1'b0 && v[0] === 1'b1, "R4 even ok", v, 8'h01);
    rd_data(v);
    send_rx(8'h07, 1, 0, 1);
    rd_reg(2'd1, v); check(v[3] === 1'b1, "R4 even err", v, 8'h09);
    rd_data(v); check(v === 8'h07, "R4 data", v, 8'h07);
    wr(2'd2, 8'h00); wr(2'd3, 8'h03); wr(2'd2, 8'h03);
    wr(2'd0, 8'h07);
    grab_tx(11, 16, b, s);
    check(s && b === {2'b10, 8'h07, 1'b0}, "R4 odd tx", b, {2'b10, 8'h07, 1'b0});
    send_rx(8'h07, 1, 0, 1);
    rd_reg(2'd1, v); check(v[3] === 1'b0, "R4 odd ok", v, 8'h01);
    rd_data(v);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_mp;
    logic [10:0] b; bit s; logic [7:0] v;
    wr(2'd3, 8'h05); wr(2'd2, 8'h0B);
    wr(2'd0, 8'h30);
    grab_tx(11, 16, b, s);
    check(s && b === {2'b11, 8'h30, 1'b0}, "R5 flag 1 tx", b, {2'b11, 8'h30, 1'b0});
    wr(2'd2, 8'h03);
    wr(2'd0, 8'h31);
    grab_tx(11, 16, b, s);
    check(s && b === {2'b10, 8'h31, 1'b0}, "R5 flag 0 tx", b, {2'b10, 8'h31, 1'b0});
    send_rx(8'h42, 1, 1, 1);
    rd_reg(2'd1, v); check(v[5:0] === 6'b000101, "R5 R6 address byte", v, 8'h05);
    rd_data(v); check(v === 8'h42, "R5 addr data", v, 8'h42);
    rd_reg(2'd1, v); check(v[5:0] === 6'b0, "R7 cleared mpbit", v, 8'h00);
    send_rx(8'h10, 1, 0, 1);
    rd_reg(2'd1, v); check(v[5:0] === 6'b000011, "R6 first data", v, 8'h03);
    rd_data(v);
    rd_reg(2'd1, v); check(v[1] === 1'b0, "R7 cleared newfrm", v, 8'h00);
    send_rx(8'h11, 1, 0, 1);
    rd_reg(2'd1, v); check(v[5:0] === 6'b000001, "R6 later data", v, 8'h01);
    rd_data(v);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_rx_errors;
    logic [7:0] v;
    wr(2'd2, 8'h02);
    send_rx(8'h5A, 0, 0, 0);
    idle(30);
    rd_reg(2'd1, v); check(v[5:0] === 6'b010001, "R8 framing", v, 8'h11);
    rd_data(v); check(v === 8'h5A, "R8 data kept", v, 8'h5A);
    rd_reg(2'd1, v); check(v[5:0] === 6'b0, "R7 ferr cleared", v, 8'h00);
    send_rx(8'h01, 0, 0, 1);
    send_rx(8'h02, 0, 0, 1);
    rd_reg(2'd1, v); check(v[5] === 1'b1 && v[0] === 1'b1, "R9 overrun", v, 8'h21);
    rd_data(v); check(v === 8'h02, "R9 newest", v, 8'h02);
    rd_reg(2'd1, v); check(v[5:0] === 6'b0, "R7 ovr cleared", v, 8'h00);
    @(negedge clk); rx_in = 1'b0; idle(4); rx_in = 1'b1; idle(60);
    rd_reg(2'd1, v); check(v[0] === 1'b0, "R12 glitch", v, 8'h00);
    send_rx(8'hC3, 0, 0, 1);
    rd_data(v); check(v === 8'hC3, "R12 next ok", v, 8'hC3);
    wr(2'd2, 8'h01);
    send_rx(8'h77, 0, 0, 1);
    rd_reg(2'd1, v); check(v[0] === 1'b0, "R10 rx off", v, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_tx_frame();
    t_cts();
    t_cfg_lock();
    t_parity();
    t_mp();
    t_rx_errors();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule